// File: doc/BRIEF.md
# Peripheral address and interrupt router

This block sits beside the configuration register file of a multifunction I/O controller. It turns the register contents into chip selects for five on-chip peripherals: a real-time clock, two UARTs, a parallel port and a game port. It also steers four peripheral interrupt requests onto four system interrupt lines (IRQ3, IRQ4, IRQ5, IRQ7). The register file drives the `cfg_*` inputs continuously. The router keeps its own copy of them, the active map. That copy is refreshed only on reset and at the moment configuration mode ends, so a half-written configuration never reaches the bus.

A two-state machine controls the copy. In state RUN the active map drives the decoders. When `cfg_active` is seen high, the transition RUN→CFG is taken. In state CFG every select is held low. CFG stays put while `cfg_active` remains high. When `cfg_active` is seen low in CFG, the transition CFG→RUN is taken, and on that same edge the active map is loaded from the `cfg_*` inputs. Reset forces RUN and loads the default map. The selects are also gated directly by `cfg_active`, so they drop in the same cycle configuration starts.

Top module: `periph_route`

## Requirements
- R1: After reset the active map holds these values: enable 0x00, RTC base register 0xB0, UART1 0xFE, UART2 0xBE, parallel 0x9E, game 0x80 and interrupt select 0xEC. With those values the RTC answers at 0x2C0–0x2C1, and no other select and no interrupt line is active.
- R2: The base address of a peripheral is its 8-bit base register shifted left by two. Each peripheral decodes an aligned window of its own size: 2 bytes for the RTC, 8 for each UART, 4 for the parallel port and 1 for the game port. Address bits below the window size are ignored in the compare, so a base that is not aligned selects the aligned window that contains it.
- R3: Enable bit 0 gates the game port, bit 1 UART1, bit 2 UART2 and bit 3 the parallel port. A disabled peripheral drives neither its select nor any interrupt line. The RTC is always enabled.
- R4: The interrupt select byte holds four 2-bit fields. Bits 7:6 serve IRQ3 (irq_line[0]) and bits 5:4 serve IRQ4 (irq_line[1]); in both, 01 names the RTC, 10 UART1 and 11 UART2. Bits 3:2 serve IRQ5 (irq_line[2]) with 01 RTC, 10 UART1, 11 parallel. Bits 1:0 serve IRQ7 (irq_line[3]) with 01 RTC, 10 UART2, 11 parallel. A line passes on the request of the device it names.
- R5: A field value of 00 leaves its line unassigned. A line is low when it is unassigned, or when the device it names is disabled or not requesting.
- R6: Fields are applied from bits 7:6 down to bits 1:0. When a device is named by more than one field, only the last of those fields assigns it. That device then drives only that one line, and the earlier lines that named it stay low.
- R7: While `cfg_active` is high, every select is low, starting in the same cycle `cfg_active` rises. Selects also stay low in the cycle between `cfg_active` falling and the next clock edge.
- R8: Changes on the `cfg_*` inputs have no effect unless configuration mode is exited. On the first clock edge at which `cfg_active` is low while the block is in CFG, all seven registers are copied together, and they take effect from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the default map |
| cfg_active | input | 1 | High while configuration mode is open |
| cfg_enable | input | 8 | Live enable register (bits 3:0 used) |
| cfg_rtc_base | input | 8 | Live RTC base register |
| cfg_uart1_base | input | 8 | Live UART1 base register |
| cfg_uart2_base | input | 8 | Live UART2 base register |
| cfg_lpt_base | input | 8 | Live parallel port base register |
| cfg_game_base | input | 8 | Live game port base register |
| cfg_irq_sel | input | 8 | Live interrupt select register |
| io_addr | input | 10 | I/O address being decoded |
| dev_irq_req | input | 4 | Requests: [0] RTC, [1] UART1, [2] UART2, [3] parallel |
| sel_out | output | 5 | Selects: [0] RTC, [1] UART1, [2] UART2, [3] parallel, [4] game |
| irq_line | output | 4 | [0] IRQ3, [1] IRQ4, [2] IRQ5, [3] IRQ7 |

## Verification
The bench targets the override rule with patterns that name one device in two, three and four fields. A design that lets every naming field drive would raise extra lines in those patterns. It probes the last byte inside each window and the first byte past it, and it uses a base that is not aligned. An off-by-one in the window mask, or a compare against the unshifted register, would select the wrong addresses there. It changes the live registers outside configuration mode and samples in the exit cycle. A design that decodes straight from the register file, or that loads one cycle late, would show the new map early or keep the old one too long. The bench also checks that the RTC and its interrupt ignore the enable byte, which catches gating applied to every device alike.

// File: rtl/periph_route_pkg.sv
package periph_route_pkg;

    localparam int REG_W    = 8;
    localparam int NUM_IRQ  = 4;   // devices that can raise interrupts
    localparam int NUM_LINE = 4;   // system interrupt lines
    localparam int NUM_SEL  = 5;   // decoded windows

    // device indices on dev_irq_req / sel_out
    localparam logic [2:0] DEV_RTC  = 3'd0;
    localparam logic [2:0] DEV_U1   = 3'd1;
    localparam logic [2:0] DEV_U2   = 3'd2;
    localparam logic [2:0] DEV_LPT  = 3'd3;
    localparam logic [2:0] DEV_NONE = 3'd4;

    typedef enum logic {
        ST_RUN = 1'b0,
        ST_CFG = 1'b1
    } route_state_e;

    typedef struct packed {
        logic [REG_W-1:0] enable;
        logic [REG_W-1:0] rtc_base;
        logic [REG_W-1:0] u1_base;
        logic [REG_W-1:0] u2_base;
        logic [REG_W-1:0] lpt_base;
        logic [REG_W-1:0] game_base;
        logic [REG_W-1:0] irq_sel;
    } route_map_t;

    // Device named by a 2-bit field of the interrupt select byte.
    // line 0 = IRQ3, 1 = IRQ4, 2 = IRQ5, 3 = IRQ7
    function automatic logic [2:0] field_device(input int line, input logic [1:0] code);
        logic [2:0] dev;
        unique case (code)
            2'b00: dev = DEV_NONE;
            2'b01: dev = DEV_RTC;
            2'b10: dev = (line <= 2) ? DEV_U1 : DEV_U2;
            default: dev = (line <= 1) ? DEV_U2 : DEV_LPT;
        endcase
        return dev;
    endfunction

endpackage

// File: rtl/route_map_fsm.sv
module route_map_fsm
    import periph_route_pkg::*;
#(
    parameter route_map_t RESET_MAP = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_active,
    input  route_map_t cfg_in,
    output route_map_t map_q,
    output logic       decode_on
);

    route_state_e state_q;
    route_state_e state_d;
    logic         load_map;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: if (cfg_active)  state_d = ST_CFG;   // RUN -> CFG
            ST_CFG: if (!cfg_active) state_d = ST_RUN;   // CFG -> RUN (commit)
            default: state_d = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // outputs of the machine
    always_comb begin
        load_map  = (state_q == ST_CFG) && !cfg_active;
        decode_on = (state_q == ST_RUN) && !cfg_active;
    end

    // active map: reset defaults, or atomic copy on configuration exit
    always_ff @(posedge clk) begin
        if (!rst_n)        map_q <= RESET_MAP;
        else if (load_map) map_q <= cfg_in;
    end

    // R8: the map only moves on the commit edge
    p_map_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> $stable(map_q));

    // R8: all fields copied together on exit
    p_map_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CFG && !cfg_active) |=> (map_q == $past(cfg_in)));

    // R7: no decoding while the machine sits in CFG
    p_cfg_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CFG) |-> !decode_on);

endmodule

// File: rtl/addr_window.sv
module addr_window #(
    parameter int ADDR_W    = 10,
    parameter int REG_W     = 8,
    parameter int SPAN_LOG2 = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  base_reg,
    input  logic              enable,
    output logic              hit
);

    localparam int SHIFT_W = REG_W + 2;

    logic [SHIFT_W-1:0] base_shifted;
    logic [ADDR_W-1:0]  base_full;
    logic [ADDR_W-1:0]  addr_blk;
    logic [ADDR_W-1:0]  base_blk;

    always_comb begin
        base_shifted = {base_reg, 2'b00};
        base_full    = ADDR_W'(base_shifted);
        addr_blk     = addr >> SPAN_LOG2;
        base_blk     = base_full >> SPAN_LOG2;
        hit          = enable && (addr_blk == base_blk);
    end

endmodule

// File: rtl/irq_steer.sv
module irq_steer
    import periph_route_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_W-1:0]    irq_sel,
    input  logic [NUM_IRQ-1:0]  dev_en,
    input  logic [NUM_IRQ-1:0]  dev_req,
    output logic [NUM_LINE-1:0] irq_line
);

    logic [2:0]          dev_of   [NUM_LINE];
    logic [NUM_LINE-1:0] owner_ok;

    // field decode, one per line; line L uses bits [7-2L : 6-2L]
    for (genvar gl = 0; gl < NUM_LINE; gl++) begin : g_field
        always_comb dev_of[gl] = field_device(gl, irq_sel[REG_W-1-2*gl -: 2]);
    end

    // a field keeps its device only if no later field names it again
    always_comb begin
        for (int l = 0; l < NUM_LINE; l++) begin
            owner_ok[l] = (dev_of[l] != DEV_NONE);
            for (int j = l + 1; j < NUM_LINE; j++) begin
                if (dev_of[j] == dev_of[l]) owner_ok[l] = 1'b0;
            end
        end
    end

    always_comb begin
        for (int l = 0; l < NUM_LINE; l++) begin
            irq_line[l] = 1'b0;
            for (int d = 0; d < NUM_IRQ; d++) begin
                if (owner_ok[l] && dev_of[l] == 3'(d))
                    irq_line[l] = dev_en[d] && dev_req[d];
            end
        end
    end

    // R6: each device drives at most one line
    for (genvar gd = 0; gd < NUM_IRQ; gd++) begin : g_chk
        logic [NUM_LINE-1:0] drives;
        always_comb begin
            for (int l = 0; l < NUM_LINE; l++)
                drives[l] = irq_line[l] && owner_ok[l] && (dev_of[l] == 3'(gd));
        end
        p_single_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(drives));
    end

    // R5: an unassigned line stays low
    p_unassigned_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sel[1:0] == 2'b00) |-> !irq_line[3]);

    // R3: a line carries nothing from a disabled UART1 when it names UART1
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_en[1] && irq_sel[7:6] == 2'b10) |-> !irq_line[0]);

endmodule

// File: rtl/periph_route.sv
module periph_route
    import periph_route_pkg::*;
#(
    parameter logic [7:0] RST_ENABLE    = 8'h00,
    parameter logic [7:0] RST_RTC_BASE  = 8'hB0,
    parameter logic [7:0] RST_U1_BASE   = 8'hFE,
    parameter logic [7:0] RST_U2_BASE   = 8'hBE,
    parameter logic [7:0] RST_LPT_BASE  = 8'h9E,
    parameter logic [7:0] RST_GAME_BASE = 8'h80,
    parameter logic [7:0] RST_IRQ_SEL   = 8'hEC,
    parameter int         RTC_SPAN_LOG2  = 1,
    parameter int         UART_SPAN_LOG2 = 3,
    parameter int         LPT_SPAN_LOG2  = 2,
    parameter int         GAME_SPAN_LOG2 = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_active,
    input  logic [7:0]   cfg_enable,
    input  logic [7:0]   cfg_rtc_base,
    input  logic [7:0]   cfg_uart1_base,
    input  logic [7:0]   cfg_uart2_base,
    input  logic [7:0]   cfg_lpt_base,
    input  logic [7:0]   cfg_game_base,
    input  logic [7:0]   cfg_irq_sel,
    input  logic [9:0]   io_addr,
    input  logic [3:0]   dev_irq_req,
    output logic [4:0]   sel_out,
    output logic [3:0]   irq_line
);

    localparam int ADDR_W = REG_W + 2;
    localparam route_map_t RESET_MAP = '{
        enable:    RST_ENABLE,
        rtc_base:  RST_RTC_BASE,
        u1_base:   RST_U1_BASE,
        u2_base:   RST_U2_BASE,
        lpt_base:  RST_LPT_BASE,
        game_base: RST_GAME_BASE,
        irq_sel:   RST_IRQ_SEL
    };
    localparam int SPAN_LOG2 [NUM_SEL] = '{RTC_SPAN_LOG2, UART_SPAN_LOG2,
                                           UART_SPAN_LOG2, LPT_SPAN_LOG2,
                                           GAME_SPAN_LOG2};

    route_map_t           cfg_live;
    route_map_t           map_q;
    logic                 decode_on;
    logic [NUM_SEL-1:0]   win_en;
    logic [REG_W-1:0]     win_base [NUM_SEL];
    logic [NUM_SEL-1:0]   win_hit;

    always_comb begin
        cfg_live = '{
            enable:    cfg_enable,
            rtc_base:  cfg_rtc_base,
            u1_base:   cfg_uart1_base,
            u2_base:   cfg_uart2_base,
            lpt_base:  cfg_lpt_base,
            game_base: cfg_game_base,
            irq_sel:   cfg_irq_sel
        };
    end

    route_map_fsm #(
        .RESET_MAP (RESET_MAP)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_active (cfg_active),
        .cfg_in     (cfg_live),
        .map_q      (map_q),
        .decode_on  (decode_on)
    );

    // window bases and enables, indexed like sel_out
    always_comb begin
        win_base[0] = map_q.rtc_base;
        win_base[1] = map_q.u1_base;
        win_base[2] = map_q.u2_base;
        win_base[3] = map_q.lpt_base;
        win_base[4] = map_q.game_base;
        win_en[0]   = 1'b1;               // RTC always mapped
        win_en[1]   = map_q.enable[1];
        win_en[2]   = map_q.enable[2];
        win_en[3]   = map_q.enable[3];
        win_en[4]   = map_q.enable[0];
    end

    for (genvar gw = 0; gw < NUM_SEL; gw++) begin : g_win
        addr_window #(
            .ADDR_W    (ADDR_W),
            .REG_W     (REG_W),
            .SPAN_LOG2 (SPAN_LOG2[gw])
        ) u_win (
            .addr     (io_addr),
            .base_reg (win_base[gw]),
            .enable   (win_en[gw]),
            .hit      (win_hit[gw])
        );
    end

    always_comb sel_out = decode_on ? win_hit : '0;

    irq_steer u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_sel  (map_q.irq_sel),
        .dev_en   (win_en[NUM_IRQ-1:0]),
        .dev_req  (dev_irq_req),
        .irq_line (irq_line)
    );

    // R7: configuration mode silences every select
    p_cfg_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_active |-> (sel_out == '0));

    // R3: a disabled UART1 never gets selected
    p_u1_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !map_q.enable[1] |-> !sel_out[1]);

    // R2: no two windows selected together under the default map
    p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (map_q == RESET_MAP) |-> $onehot0(sel_out));

endmodule

// File: tb/sim_periph_route.sv
module sim_periph_route;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_active;
    logic [7:0] cfg_enable, cfg_rtc_base, cfg_uart1_base, cfg_uart2_base;
    logic [7:0] cfg_lpt_base, cfg_game_base, cfg_irq_sel;
    logic [9:0] io_addr;
    logic [3:0] dev_irq_req;
    logic [4:0] sel_out;
    logic [3:0] irq_line;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    periph_route u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_active     (cfg_active),
        .cfg_enable     (cfg_enable),
        .cfg_rtc_base   (cfg_rtc_base),
        .cfg_uart1_base (cfg_uart1_base),
        .cfg_uart2_base (cfg_uart2_base),
        .cfg_lpt_base   (cfg_lpt_base),
        .cfg_game_base  (cfg_game_base),
        .cfg_irq_sel    (cfg_irq_sel),
        .io_addr        (io_addr),
        .dev_irq_req    (dev_irq_req),
        .sel_out        (sel_out),
        .irq_line       (irq_line)
    );

    // {enable[3:0], irq_sel[7:0], addr[9:0], req[3:0], exp_sel[4:0], exp_irq[3:0]}
    localparam int NV = 12;
    localparam logic [34:0] VEC [NV] = '{
        {4'h0, 8'hEC, 10'h3F8, 4'hF,    5'b00000, 4'b0000},
        {4'hF, 8'hEC, 10'h3F8, 4'hF,    5'b00010, 4'b0111},
        {4'hF, 8'hEC, 10'h3FF, 4'b0010, 5'b00010, 4'b0010},
        {4'hF, 8'h55, 10'h2C1, 4'b0001, 5'b00001, 4'b1000},
        {4'h0, 8'h40, 10'h2C0, 4'b0001, 5'b00001, 4'b0001},
        {4'hF, 8'hA8, 10'h2F8, 4'b0010, 5'b00100, 4'b0100},
        {4'hF, 8'hF3, 10'h27B, 4'b1100, 5'b01000, 4'b1010},
        {4'hF, 8'h00, 10'h27C, 4'hF,    5'b00000, 4'b0000},
        {4'h1, 8'hEC, 10'h200, 4'hF,    5'b10000, 4'b0000},
        {4'hF, 8'h0E, 10'h201, 4'hF,    5'b00000, 4'b1100},
        {4'h6, 8'h9E, 10'h2F7, 4'hF,    5'b00000, 4'b1011},
        {4'hF, 8'h5A, 10'h2C2, 4'b0001, 5'b00000, 4'b0010}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [7:0] en, input logic [7:0] rtc, input logic [7:0] u1,
                           input logic [7:0] u2, input logic [7:0] lpt, input logic [7:0] game,
                           input logic [7:0] isel);
        cfg_enable = en; cfg_rtc_base = rtc; cfg_uart1_base = u1; cfg_uart2_base = u2;
        cfg_lpt_base = lpt; cfg_game_base = game; cfg_irq_sel = isel;
    endtask

    // open configuration, write, close; returns at a negedge with the new map live
    task automatic commit(input logic [7:0] en, input logic [7:0] rtc, input logic [7:0] u1,
                          input logic [7:0] u2, input logic [7:0] lpt, input logic [7:0] game,
                          input logic [7:0] isel);
        @(negedge clk);
        cfg_active = 1'b1;
        set_cfg(en, rtc, u1, u2, lpt, game, isel);
        @(negedge clk);
        cfg_active = 1'b0;
        @(negedge clk);
    endtask

    task automatic probe(input logic [9:0] a, input logic [3:0] r);
        io_addr = a; dev_irq_req = r;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_active = 1'b0;
        set_cfg(8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h55);
        io_addr = '0; dev_irq_req = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: defaults, not the live inputs
        probe(10'h2C0, 4'hF); check("R1 rtc lo", 8'(sel_out), 8'h01);
        check("R1 irq", 8'(irq_line), 8'h0);
        probe(10'h2C1, 4'hF); check("R1 rtc hi", 8'(sel_out), 8'h01);
        probe(10'h3F8, 4'hF); check("R1 uart1 off", 8'(sel_out), 8'h00);
        probe(10'h000, 4'hF); check("R1 live base ignored", 8'(sel_out), 8'h00);

        // table walk
        for (int i = 0; i < NV; i++) begin
            commit({4'h0, VEC[i][34:31]}, 8'hB0, 8'hFE, 8'hBE, 8'h9E, 8'h80, VEC[i][30:23]);
            probe(VEC[i][22:13], VEC[i][12:9]);
            check($sformatf("R2,R3 select vec %0d", i), 8'(sel_out), 8'(VEC[i][8:4]));
            check($sformatf("R4,R5,R6 irq vec %0d", i), 8'(irq_line), 8'(VEC[i][3:0]));
        end

        // R2: relocation and an unaligned base
        commit(8'h0F, 8'h38, 8'hFF, 8'hBE, 8'h9E, 8'h80, 8'h00);
        probe(10'h0E1, 4'h0); check("R2 rtc moved", 8'(sel_out), 8'h01);
        probe(10'h0E2, 4'h0); check("R2 rtc edge", 8'(sel_out), 8'h00);
        probe(10'h3F8, 4'h0); check("R2 unaligned uart1", 8'(sel_out), 8'h02);
        probe(10'h2C0, 4'h0); check("R2 old rtc gone", 8'(sel_out), 8'h00);

        // R7: selects drop in the cycle configuration opens
        probe(10'h0E0, 4'h0);
        @(negedge clk); cfg_active = 1'b1; #1;
        check("R7 cfg same cycle", 8'(sel_out), 8'h00);
        @(negedge clk); #1;
        check("R7 cfg held", 8'(sel_out), 8'h00);
        set_cfg(8'h0F, 8'hB0, 8'hFE, 8'hBE, 8'h9E, 8'h80, 8'h00);
        @(negedge clk); cfg_active = 1'b0; io_addr = 10'h2C0; #1;
        check("R7 exit cycle quiet", 8'(sel_out), 8'h00);
        @(negedge clk); #1;
        check("R8 commit on exit", 8'(sel_out), 8'h01);

        // R8: live changes without an exit are ignored
        set_cfg(8'h0F, 8'h38, 8'hFE, 8'hBE, 8'h9E, 8'h80, 8'h40);
        repeat (3) @(negedge clk);
        probe(10'h0E0, 4'h1); check("R8 no early move", 8'(sel_out), 8'h00);
        check("R8 irq map held", 8'(irq_line), 8'h0);
        probe(10'h2C0, 4'h1); check("R8 old map held", 8'(sel_out), 8'h01);

        // R1: reset restores defaults mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        probe(10'h3F8, 4'hF); check("R1 reset again uart1", 8'(sel_out), 8'h00);
        probe(10'h2C0, 4'hF); check("R1 reset again rtc", 8'(sel_out), 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule